// File: doc/BRIEF.md
# Fixed-Period Fan PWM Controller

This block drives one cooling fan from a single pulse-width output in two-wire mode. Software reaches it over a small 32-bit register bus of word-aligned reads and writes. It sets only an enable bit, a mode bit and an 8-bit duty value. The period is fixed by the `STEP_CYCLES` parameter. One period is split into 255 steps of `STEP_CYCLES` clocks each. A prescaler counts the clocks in a step and a step counter counts the steps. The output is high, which is the active level, while the step counter is below the duty value. A second register holds a 16-bit maximum-speed value that is stored and read back only.

A three-state machine produces the waveform. `PWM_IDLE` holds the output low while the block is disabled. `PWM_ON` drives the output high and `PWM_OFF` drives it low. The transitions are:
- START_HIGH: `PWM_IDLE` to `PWM_ON`.
- START_LOW: `PWM_IDLE` to `PWM_OFF`.
- FALL: `PWM_ON` to `PWM_OFF`, when the next step reaches the duty value.
- RISE: `PWM_OFF` to `PWM_ON`, when the next step wraps below the duty value.
- STOP: `PWM_ON` or `PWM_OFF` to `PWM_IDLE`, when the enable bit clears.

While the block is disabled, both counters are parked at the wrap point. The first enabled edge therefore starts step 0 of a fresh period. A duty write acts at once, so only the period in which it lands can mix the old and new settings.

Top module: `fan_pwm_ctrl`

## Requirements
- R1: After reset, both registers read 0 and `fan_pwm` is low.
- R2: Word 0 (byte offset 0x0) holds enable in bit 0, mode in bit 1 and duty in bits 23:16. Its other bits ignore writes and read 0.
- R3: Word 1 (byte offset 0x4) holds the maximum-speed value in bits 15:0, and bits 31:16 read 0. Other word offsets ignore writes and read 0. Read data appears on `rsp_rdata` one clock after the read request is sampled and holds until the next read.
- R4: While enabled with 0 < duty < 255, rising edges of `fan_pwm` are exactly 255*STEP_CYCLES clocks apart.
- R5: In steady state, any window of 255*STEP_CYCLES clocks holds exactly duty*STEP_CYCLES high cycles. Duty 0 keeps the output low and duty 255 keeps it high.
- R6: Clearing enable drives `fan_pwm` low at the second clock edge after the write is sampled. The output stays low while disabled.
- R7: Setting enable with duty > 0 raises `fan_pwm` at the second clock edge after the write is sampled. The first high pulse lasts exactly duty*STEP_CYCLES clocks and is followed by (255-duty)*STEP_CYCLES low clocks.
- R8: A duty write sampled on the same edge as a period wrap yields exactly new_duty*STEP_CYCLES high clocks in the period that follows.
- R9: The mode bit is stored and read back, but it has no effect on the waveform.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Bus request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address; bits 1:0 are ignored |
| req_wdata | input | 32 | Write data |
| rsp_rdata | output | 32 | Registered read data |
| fan_pwm | output | 1 | Fan drive, active high |

## Verification
A register write can land on the same clock edge at which the step counter wraps. That edge both starts a new period and loads a new duty value. The bench provokes this by enabling the block, counting exactly one period of clocks, and then issuing a duty write so that it is sampled on the wrap edge. It judges the outcome by counting the high cycles in the next full period, which must match the new duty with no leftover from the old one.

// File: rtl/fanpwm_pkg.sv
package fanpwm_pkg;
    localparam int DUTY_W     = 8;
    localparam int STEPS      = 255;
    localparam int REG_W      = 32;
    localparam int SPEED_W    = 16;
    localparam int CTRL_WORD  = 0;
    localparam int SPEED_WORD = 1;
    localparam int EN_BIT     = 0;
    localparam int MODE_BIT   = 1;
    localparam int DUTY_LSB   = 16;

    typedef enum logic [1:0] {
        PWM_IDLE = 2'd0,
        PWM_ON   = 2'd1,
        PWM_OFF  = 2'd2
    } pwm_state_e;
endpackage

// File: rtl/fanpwm_regs.sv
module fanpwm_regs
    import fanpwm_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    input  logic                 req_write,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [REG_W-1:0]     req_wdata,
    output logic [REG_W-1:0]     rsp_rdata,
    output logic                 run_en,
    output logic                 mode_sel,
    output logic [DUTY_W-1:0]    duty_val
);
    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]   word_idx;
    logic [SPEED_W-1:0] speed_q;
    logic [REG_W-1:0]   rd_mux;
    logic               hit_ctrl;
    logic               hit_speed;

    assign word_idx  = req_addr[ADDR_W-1:2];
    assign hit_ctrl  = (word_idx == IDX_W'(CTRL_WORD));
    assign hit_speed = (word_idx == IDX_W'(SPEED_WORD));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_en   <= 1'b0;
            mode_sel <= 1'b0;
            duty_val <= '0;
            speed_q  <= '0;
        end else if (req_valid && req_write) begin
            if (hit_ctrl) begin
                run_en   <= req_wdata[EN_BIT];
                mode_sel <= req_wdata[MODE_BIT];
                duty_val <= req_wdata[DUTY_LSB +: DUTY_W];
            end
            if (hit_speed) begin
                speed_q <= req_wdata[SPEED_W-1:0];
            end
        end
    end

    always_comb begin
        rd_mux = '0;
        if (hit_ctrl) begin
            rd_mux[EN_BIT]                = run_en;
            rd_mux[MODE_BIT]              = mode_sel;
            rd_mux[DUTY_LSB +: DUTY_W]    = duty_val;
        end else if (hit_speed) begin
            rd_mux[SPEED_W-1:0] = speed_q;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_rdata <= '0;
        end else if (req_valid && !req_write) begin
            rsp_rdata <= rd_mux;
        end
    end
endmodule

// File: rtl/fanpwm_prescale.sv
module fanpwm_prescale
    import fanpwm_pkg::*;
#(
    parameter int STEP_CYCLES = 15686
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    output logic [DUTY_W-1:0] step_cur,
    output logic [DUTY_W-1:0] step_nxt
);
    localparam int PRE_W = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1;
    localparam logic [PRE_W-1:0]  PRE_LAST  = PRE_W'(STEP_CYCLES - 1);
    localparam logic [DUTY_W-1:0] STEP_LAST = DUTY_W'(STEPS - 1);

    logic [PRE_W-1:0] pre_q;
    logic [PRE_W-1:0] pre_n;

    // Parked at the wrap point while stopped, so the first run edge opens step 0.
    always_comb begin
        if (!run) begin
            pre_n    = PRE_LAST;
            step_nxt = STEP_LAST;
        end else if (pre_q == PRE_LAST) begin
            pre_n    = '0;
            step_nxt = (step_cur == STEP_LAST) ? '0 : step_cur + 1'b1;
        end else begin
            pre_n    = pre_q + 1'b1;
            step_nxt = step_cur;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q    <= PRE_LAST;
            step_cur <= STEP_LAST;
        end else begin
            pre_q    <= pre_n;
            step_cur <= step_nxt;
        end
    end
endmodule

// File: rtl/fanpwm_fsm.sv
module fanpwm_fsm
    import fanpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [DUTY_W-1:0] duty,
    input  logic [DUTY_W-1:0] step_nxt,
    output logic              pwm_out
);
    pwm_state_e state_q;
    pwm_state_e state_d;
    logic       below;

    assign below = (step_nxt < duty);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWM_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWM_IDLE: if (run) state_d = below ? PWM_ON : PWM_OFF;   // START_HIGH / START_LOW
            PWM_ON: begin
                if (!run)        state_d = PWM_IDLE;                  // STOP
                else if (!below) state_d = PWM_OFF;                   // FALL
            end
            PWM_OFF: begin
                if (!run)        state_d = PWM_IDLE;                  // STOP
                else if (below)  state_d = PWM_ON;                    // RISE
            end
            default:             state_d = PWM_IDLE;
        endcase
    end

    always_comb begin
        pwm_out = (state_q == PWM_ON);
    end
endmodule

// File: rtl/fan_pwm_ctrl.sv
module fan_pwm_ctrl
    import fanpwm_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int STEP_CYCLES = 15686
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic [31:0]       rsp_rdata,
    output logic              fan_pwm
);
    logic              run_en;
    logic              mode_sel;
    logic [DUTY_W-1:0] duty_val;
    logic [DUTY_W-1:0] step_cur;
    logic [DUTY_W-1:0] step_nxt;
    logic              mode_unused;

    // Only two-wire drive exists; the mode bit is storage for software.
    assign mode_unused = mode_sel;

    fanpwm_regs #(.ADDR_W(ADDR_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_write (req_write),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .rsp_rdata (rsp_rdata),
        .run_en    (run_en),
        .mode_sel  (mode_sel),
        .duty_val  (duty_val)
    );

    fanpwm_prescale #(.STEP_CYCLES(STEP_CYCLES)) u_pre (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .step_cur (step_cur),
        .step_nxt (step_nxt)
    );

    fanpwm_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run_en),
        .duty     (duty_val),
        .step_nxt (step_nxt),
        .pwm_out  (fan_pwm)
    );
endmodule

// File: rtl/fanpwm_chk.sv
module fanpwm_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       rsp_rdata,
    input logic              fan_pwm,
    input logic              run_en,
    input logic [7:0]        duty_val,
    input logic [7:0]        step_cur
);
    logic rd_ctrl;
    logic rd_speed;
    logic rd_other;

    assign rd_ctrl  = req_valid && !req_write && (req_addr[ADDR_W-1:2] == '0);
    assign rd_speed = req_valid && !req_write && (req_addr[ADDR_W-1:2] == (ADDR_W-2)'(1));
    assign rd_other = req_valid && !req_write && !rd_ctrl && !rd_speed;

    AST_STOPPED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_en |=> !fan_pwm);                                          // R6
    AST_DUTY_ZERO_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (duty_val == 8'd0) |=> !fan_pwm);                               // R5
    AST_DUTY_FULL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (run_en && duty_val == 8'hFF) |=> fan_pwm);                     // R5
    AST_STEP_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        step_cur != 8'hFF);                                             // R4
    AST_CTRL_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ctrl |=> (rsp_rdata[31:24] == 8'd0 && rsp_rdata[15:2] == 14'd0)); // R2
    AST_SPEED_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_speed |=> (rsp_rdata[31:16] == 16'd0));                      // R3
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        rd_other |=> (rsp_rdata == 32'd0));                             // R3
    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && !req_write) |=> $stable(rsp_rdata));             // R3
endmodule

bind fan_pwm_ctrl fanpwm_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .rsp_rdata (rsp_rdata),
    .fan_pwm   (fan_pwm),
    .run_en    (run_en),
    .duty_val  (duty_val),
    .step_cur  (step_cur)
);

// File: tb/sim_fan_pwm_ctrl.sv
module sim_fan_pwm_ctrl;
    localparam int S  = 4;
    localparam int P  = 255 * S;
    localparam int AW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic [31:0]   rsp_rdata;
    logic          fan_pwm;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } sb_item_t;
    sb_item_t sbq[$];
    logic     took_rd = 1'b0;

    always #5 clk = ~clk;

    fan_pwm_ctrl #(.ADDR_W(AW), .STEP_CYCLES(S)) u0 (
        .clk (clk), .rst_n (rst_n), .req_valid (req_valid), .req_write (req_write),
        .req_addr (req_addr), .req_wdata (req_wdata), .rsp_rdata (rsp_rdata), .fan_pwm (fan_pwm)
    );

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: a read sampled at a rising edge is compared at the next falling edge.
    always @(posedge clk) took_rd <= req_valid && !req_write;

    always @(negedge clk) begin
        if (took_rd) begin
            if (sbq.size() == 0) begin
                check(1'b0, "scoreboard underflow", 0, 1);
            end else begin
                sb_item_t it;
                it = sbq.pop_front();
                check(rsp_rdata == it.exp, it.tag, rsp_rdata, it.exp);
            end
        end
    end

    task automatic bus_wr(input logic [AW-1:0] a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic bus_rd(input logic [AW-1:0] a, input logic [31:0] e, input string tag);
        sb_item_t it;
        it.exp = e; it.tag = tag;
        @(negedge clk);
        sbq.push_back(it);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (fan_pwm) hi++;
        end
    endtask

    task automatic rise_gap(output int gap);
        do @(negedge clk); while (fan_pwm);
        do @(negedge clk); while (!fan_pwm);
        gap = 0;
        do begin @(negedge clk); gap++; end while (fan_pwm);
        do begin @(negedge clk); gap++; end while (!fan_pwm);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int hi;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        check(fan_pwm == 1'b0, "R1 output after reset", fan_pwm, 0);
        bus_rd(4'h0, 32'h0, "R1 word0 after reset");
        bus_rd(4'h4, 32'h0, "R1 word1 after reset");

        // R2 field layout, spare bits dropped
        bus_wr(4'h0, 32'hFF55_FFFE);
        bus_rd(4'h0, 32'h0055_0002, "R2 word0 fields");
        check(fan_pwm == 1'b0, "R2 enable clear keeps output low", fan_pwm, 0);

        // R3 speed word and unmapped words
        bus_wr(4'h4, 32'hABCD_0FA0);
        bus_rd(4'h4, 32'h0000_0FA0, "R3 word1 readback");
        bus_wr(4'h8, 32'hFFFF_FFFF);
        bus_rd(4'h8, 32'h0, "R3 unmapped word reads 0");
        bus_rd(4'hC, 32'h0, "R3 unmapped word reads 0");
        bus_rd(4'h0, 32'h0055_0002, "R3 unmapped write left word0");
        bus_rd(4'h4, 32'h0000_0FA0, "R3 unmapped write left word1");

        // R7 clean start
        bus_wr(4'h0, 32'h0064_0000);
        bus_wr(4'h0, 32'h0064_0001);
        check(fan_pwm == 1'b0, "R7 low one edge after enable", fan_pwm, 0);
        n = 0;
        @(negedge clk);
        while (fan_pwm && n < 2 * P) begin n++; @(negedge clk); end
        check(n == 100 * S, "R7 first high pulse", n, 100 * S);
        n = 0;
        while (!fan_pwm && n < 2 * P) begin n++; @(negedge clk); end
        check(n == 155 * S, "R7 first low stretch", n, 155 * S);

        // R4 period
        rise_gap(n);
        check(n == P, "R4 rise to rise", n, P);

        // R5 ratio
        count_high(P, hi);
        check(hi == 100 * S, "R5 duty 100", hi, 100 * S);
        bus_wr(4'h0, 32'h0000_0001);
        repeat (2) @(negedge clk);
        count_high(P, hi);
        check(hi == 0, "R5 duty 0", hi, 0);
        bus_wr(4'h0, 32'h00FF_0001);
        repeat (2) @(negedge clk);
        count_high(P, hi);
        check(hi == P, "R5 duty 255", hi, P);
        bus_wr(4'h0, 32'h00C8_0001);
        repeat (P) @(negedge clk);
        count_high(P, hi);
        check(hi == 200 * S, "R5 duty 200", hi, 200 * S);

        // R8 duty write on the wrap edge
        bus_wr(4'h0, 32'h0064_0000);
        bus_wr(4'h0, 32'h0064_0001);
        repeat (P - 1) @(negedge clk);
        bus_wr(4'h0, 32'h0032_0001);
        count_high(P, hi);
        check(hi == 50 * S, "R8 period after wrap-edge write", hi, 50 * S);
        rise_gap(n);
        check(n == P, "R8 period length kept", n, P);

        // R9 mode bit has no effect
        bus_wr(4'h0, 32'h0032_0003);
        count_high(P, hi);
        check(hi == 50 * S, "R9 mode set, same ratio", hi, 50 * S);
        bus_rd(4'h0, 32'h0032_0003, "R9 mode readback");

        // R6 disable
        bus_wr(4'h0, 32'h00FF_0001);
        repeat (3) @(negedge clk);
        bus_wr(4'h0, 32'h00FF_0000);
        @(negedge clk);
        check(fan_pwm == 1'b0, "R6 low two edges after disable", fan_pwm, 0);
        count_high(P, hi);
        check(hi == 0, "R6 stays low", hi, 0);
        bus_rd(4'h0, 32'h00FF_0000, "R6 enable readback");

        repeat (3) @(negedge clk);
        check(sbq.size() == 0, "R3 scoreboard drained", sbq.size(), 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule